// File: doc/BRIEF.md
# Dual-Channel Disk Register Window Decoder

This block sits between a host programmed-I/O request port and up to four drive register ports, arranged as two channels with two drives each. Every request address is compared against five programmable address windows: a command window and a control window for each channel, plus one bus-master window. The block reports the matching region, the channel and the offset relative to the window base in the same cycle as the request.

The block watches writes to the drive-select register of each command window and keeps one selected-drive bit per channel. Command and control accesses are forwarded to the selected drive one cycle after they are accepted. A 32-bit access to the data port is split into two 16-bit drive beats. Bus-master accesses are decoded and reported, but they never reach a drive. Bad sizes, misses and absent drives are flagged or dropped.

Top module: `disk_window_decoder`

## Requirements
- R1: Windows are tested in fixed priority: primary command (window 0), primary control (1), secondary command (2), secondary control (3), bus-master (4). The first window with base <= address < base + span wins, and `dec_offset` is the address minus that base. Spans are 8, 4 and 16 bytes for command, control and bus-master windows.
- R2: A configuration write (`cfg_we`, `cfg_win` = window number, `cfg_base`) loads that window's base only when `cfg_base` is nonzero. A zero value, or a window number above 4, leaves every base unchanged. All bases reset to 0.
- R3: `dec_region` encodes command = 0, control = 1, bus-master = 2 and no hit = 3. For a bus-master hit, `dec_chan` is 0 when the offset is below half the span and 1 otherwise.
- R4: An accepted access that hits no window raises `dec_miss` in its accept cycle and causes no drive access.
- R5: An accepted byte write to command offset 6 loads that channel's selected-drive bit from data bit 4. That same write is forwarded to the newly selected drive. Both bits reset to 0.
- R6: The drive index `drv_idx` equals channel × 2 + that channel's selected-drive bit.
- R7: Command offset 0 is the data port. A 16-bit access (`req_size` = 1) there gives one beat. A 32-bit access (`req_size` = 2) gives two beats on consecutive cycles, the low half first and then the high half. `req_ready` is low during the low beat.
- R8: All other command and control offsets, including control offset 0, accept byte accesses only (`req_size` = 0). A wrong size, or `req_size` = 3, raises `dec_size_err` in the accept cycle, and no drive access follows. A byte at the data port is also a size error.
- R9: While `io_en` is low, requests raise no flag, reach no drive and leave the selected-drive bits unchanged.
- R10: An access to a drive whose `drv_present` bit is clear is dropped, and bus-master hits never produce a drive access.
- R11: Each beat appears on the drive port in the cycle after the request is accepted or after the previous beat. A byte beat carries `{8'h00, data[7:0]}`. Read responses are as follows:
  - a byte read returns `drv_rdata[7:0]` zero-extended, with `resp_valid` high in its beat cycle;
  - a 16-bit read returns `drv_rdata` zero-extended;
  - a 32-bit read returns `{high-beat rdata, low-beat rdata}` in the high-beat cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_en | input | 1 | I/O decode enable |
| cfg_we | input | 1 | Window base write strobe |
| cfg_win | input | 3 | Window number to program |
| cfg_base | input | AW | New base address |
| drv_present | input | 4 | One bit per attached drive |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half, 2 word, 3 invalid |
| req_addr | input | AW | Request address |
| req_wdata | input | 32 | Write data |
| dec_region | output | 2 | Decoded region code |
| dec_chan | output | 1 | Decoded channel |
| dec_offset | output | OFF_W | Offset inside the window |
| dec_miss | output | 1 | Accepted access hit no window |
| dec_size_err | output | 1 | Accepted access had an illegal size |
| drv_req | output | 1 | Drive beat valid |
| drv_write | output | 1 | Drive beat direction |
| drv_idx | output | 2 | Target drive number |
| drv_ctl | output | 1 | 1 = control register, 0 = command register |
| drv_offset | output | OFF_W | Register offset at the drive |
| drv_wdata | output | 16 | Beat write data |
| drv_rdata | input | 16 | Drive read data for the current beat |
| resp_valid | output | 1 | Read result valid |
| resp_data | output | 32 | Read result |

## Verification
A stale or wrong selected-drive bit first shows on `drv_idx` one cycle after the next accepted command or control access to that channel. If that drive is absent, it shows instead as a missing beat. A corrupted window base shows at once on `dec_region` and `dec_offset` for the next request in that address range. A broken split sequence shows within two cycles of a 32-bit data-port access: beats come out of order or are missing, the high-half data is wrong, or `req_ready` does not drop. The scoreboard compares every drive beat and read result against a queue of expected beats. It also flags any beat that arrives when no beat is expected.

// File: rtl/disk_win_pkg.sv
package disk_win_pkg;

  localparam int NUM_WIN = 5;

  typedef enum logic [1:0] {
    RGN_CMD  = 2'd0,
    RGN_CTL  = 2'd1,
    RGN_BM   = 2'd2,
    RGN_NONE = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    BEAT_BYTE = 2'd0,
    BEAT_HALF = 2'd1,
    BEAT_LO   = 2'd2,
    BEAT_HI   = 2'd3
  } beat_e;

  // half-open range test on widened operands
  function automatic logic in_span(input logic [31:0] addr,
                                   input logic [31:0] base,
                                   input logic [31:0] span);
    return (addr >= base) && ((addr - base) < span);
  endfunction

  function automatic int unsigned max3(input int unsigned a, b, c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // window number -> region kind
  function automatic region_e region_of(input logic [2:0] w);
    if (w == 3'd4) return RGN_BM;
    return w[0] ? RGN_CTL : RGN_CMD;
  endfunction

endpackage

// File: rtl/disk_win_decode.sv
module disk_win_decode
  import disk_win_pkg::*;
#(
  parameter int AW       = 16,
  parameter int CMD_SPAN = 8,
  parameter int CTL_SPAN = 4,
  parameter int BM_SPAN  = 16,
  parameter int OFF_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_win,
  input  logic [AW-1:0]    cfg_base,
  input  logic [AW-1:0]    addr,
  output region_e          region,
  output logic             chan,
  output logic [OFF_W-1:0] offset
);

  function automatic int unsigned span_of(input int w);
    if (w == 4) return BM_SPAN;
    return (w % 2 == 1) ? CTL_SPAN : CMD_SPAN;
  endfunction

  logic [NUM_WIN-1:0][AW-1:0] base_q;
  logic [NUM_WIN-1:0]         hit;
  logic [2:0]                 win_idx;
  logic [AW-1:0]              rel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
    end else begin
      for (int w = 0; w < NUM_WIN; w++) begin
        if (cfg_we && cfg_win == 3'(w) && cfg_base != '0)
          base_q[w] <= cfg_base;
      end
    end
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign hit[w] = in_span(32'(addr), 32'(base_q[w]), 32'(span_of(w)));
  end

  // lowest-numbered hit wins
  always_comb begin
    win_idx = 3'd0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hit[w]) win_idx = 3'(w);
    end
  end

  assign rel    = addr - base_q[win_idx];
  assign offset = OFF_W'(rel);
  assign region = (|hit) ? region_of(win_idx) : RGN_NONE;

  always_comb begin
    if (!(|hit))               chan = 1'b0;
    else if (win_idx == 3'd4)  chan = (rel >= AW'(BM_SPAN / 2));
    else                       chan = win_idx[1];
  end

  p_zero_base_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_base == '0 || cfg_win > 3'd4)) |=> $stable(base_q));

endmodule

// File: rtl/disk_drive_select.sv
module disk_drive_select (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_wr,
  input  logic       sel_chan,
  input  logic       sel_bit,
  output logic [1:0] sel_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)      sel_q <= 2'b00;
    else if (sel_wr) sel_q[sel_chan] <= sel_bit;
  end

  p_sel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_wr |=> $stable(sel_q));

endmodule

// File: rtl/disk_access_seq.sv
module disk_access_seq
  import disk_win_pkg::*;
#(
  parameter int OFF_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             go_write,
  input  logic [1:0]       go_idx,
  input  logic             go_ctl,
  input  logic [OFF_W-1:0] go_off,
  input  beat_e            go_kind,
  input  logic [31:0]      go_wdata,
  input  logic [15:0]      drv_rdata,
  output logic             ready,
  output logic             drv_req,
  output logic             drv_write,
  output logic [1:0]       drv_idx,
  output logic             drv_ctl,
  output logic [OFF_W-1:0] drv_offset,
  output logic [15:0]      drv_wdata,
  output logic             resp_valid,
  output logic [31:0]      resp_data
);

  logic             beat_v, hi_pend;
  beat_e            beat_kind;
  logic [15:0]      hi_data, lo_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_v     <= 1'b0;
      beat_kind  <= BEAT_BYTE;
      hi_pend    <= 1'b0;
      hi_data    <= '0;
      lo_hold    <= '0;
      drv_write  <= 1'b0;
      drv_idx    <= '0;
      drv_ctl    <= 1'b0;
      drv_offset <= '0;
      drv_wdata  <= '0;
    end else if (hi_pend) begin
      beat_v    <= 1'b1;
      beat_kind <= BEAT_HI;
      drv_wdata <= hi_data;
      lo_hold   <= drv_rdata;
      hi_pend   <= 1'b0;
    end else if (go) begin
      beat_v     <= 1'b1;
      beat_kind  <= go_kind;
      drv_write  <= go_write;
      drv_idx    <= go_idx;
      drv_ctl    <= go_ctl;
      drv_offset <= go_off;
      drv_wdata  <= (go_kind == BEAT_BYTE) ? {8'h00, go_wdata[7:0]} : go_wdata[15:0];
      hi_pend    <= (go_kind == BEAT_LO);
      hi_data    <= go_wdata[31:16];
    end else begin
      beat_v <= 1'b0;
    end
  end

  assign ready      = !hi_pend;
  assign drv_req    = beat_v;
  assign resp_valid = beat_v && !drv_write && (beat_kind != BEAT_LO);

  always_comb begin
    case (beat_kind)
      BEAT_BYTE: resp_data = {24'h0, drv_rdata[7:0]};
      BEAT_HALF: resp_data = {16'h0, drv_rdata};
      BEAT_HI:   resp_data = {drv_rdata, lo_hold};
      default:   resp_data = '0;
    endcase
  end

  p_split_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_v && beat_kind == BEAT_LO) |=> (beat_v && beat_kind == BEAT_HI && $stable(drv_idx)));
  p_busy_in_low_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_v && beat_kind == BEAT_LO) |-> !ready);
  p_no_go_while_split_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hi_pend |-> !go);

endmodule

// File: rtl/disk_window_decoder.sv
module disk_window_decoder
  import disk_win_pkg::*;
#(
  parameter int AW       = 16,
  parameter int CMD_SPAN = 8,
  parameter int CTL_SPAN = 4,
  parameter int BM_SPAN  = 16,
  parameter int SEL_OFF  = 6,
  parameter int SEL_BIT  = 4,
  localparam int OFF_W   = $clog2(max3(CMD_SPAN, CTL_SPAN, BM_SPAN))
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_en,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_win,
  input  logic [AW-1:0]    cfg_base,
  input  logic [3:0]       drv_present,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [1:0]       req_size,
  input  logic [AW-1:0]    req_addr,
  input  logic [31:0]      req_wdata,
  output logic [1:0]       dec_region,
  output logic             dec_chan,
  output logic [OFF_W-1:0] dec_offset,
  output logic             dec_miss,
  output logic             dec_size_err,
  output logic             drv_req,
  output logic             drv_write,
  output logic [1:0]       drv_idx,
  output logic             drv_ctl,
  output logic [OFF_W-1:0] drv_offset,
  output logic [15:0]      drv_wdata,
  input  logic [15:0]      drv_rdata,
  output logic             resp_valid,
  output logic [31:0]      resp_data
);

  region_e    rgn;
  logic       accept, is_reg, data_port, size_ok, sel_wr, drive_bit, go;
  logic [1:0] sel_q, tgt_idx;
  beat_e      kind;

  disk_win_decode #(
    .AW(AW), .CMD_SPAN(CMD_SPAN), .CTL_SPAN(CTL_SPAN), .BM_SPAN(BM_SPAN), .OFF_W(OFF_W)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_base(cfg_base),
    .addr(req_addr), .region(rgn), .chan(dec_chan), .offset(dec_offset)
  );

  assign dec_region = rgn;
  assign accept     = req_valid && req_ready && io_en;
  assign is_reg     = (rgn == RGN_CMD) || (rgn == RGN_CTL);
  assign data_port  = (rgn == RGN_CMD) && (dec_offset == '0);
  assign size_ok    = data_port ? (req_size == 2'd1 || req_size == 2'd2) : (req_size == 2'd0);

  assign dec_miss     = accept && (rgn == RGN_NONE);
  assign dec_size_err = accept && is_reg && !size_ok;

  // drive-select snoop
  assign sel_wr    = accept && req_write && (rgn == RGN_CMD) &&
                     (dec_offset == OFF_W'(SEL_OFF)) && (req_size == 2'd0);
  assign drive_bit = sel_wr ? req_wdata[SEL_BIT] : sel_q[dec_chan];
  assign tgt_idx   = {dec_chan, drive_bit};
  assign go        = accept && is_reg && size_ok && drv_present[tgt_idx];

  always_comb begin
    case (req_size)
      2'd0:    kind = BEAT_BYTE;
      2'd1:    kind = BEAT_HALF;
      default: kind = BEAT_LO;
    endcase
  end

  disk_drive_select u_select (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_chan(dec_chan),
    .sel_bit(req_wdata[SEL_BIT]), .sel_q(sel_q)
  );

  disk_access_seq #(.OFF_W(OFF_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .go_write(req_write), .go_idx(tgt_idx),
    .go_ctl(rgn == RGN_CTL), .go_off(dec_offset), .go_kind(kind), .go_wdata(req_wdata),
    .drv_rdata(drv_rdata), .ready(req_ready), .drv_req(drv_req), .drv_write(drv_write),
    .drv_idx(drv_idx), .drv_ctl(drv_ctl), .drv_offset(drv_offset), .drv_wdata(drv_wdata),
    .resp_valid(resp_valid), .resp_data(resp_data)
  );

  p_miss_no_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_miss |=> !drv_req);
  p_size_err_no_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_size_err |=> !drv_req);
  p_io_off_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !io_en) |=> (!drv_req && $stable(sel_q)));
  p_idx_tracks_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drv_req |-> (drv_idx[0] == sel_q[drv_idx[1]]));
  p_bm_no_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rgn == RGN_BM) |=> !drv_req);

endmodule

// File: tb/test_disk_window_decoder.sv
module test_disk_window_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_en = 1'b0, cfg_we = 1'b0;
  logic [2:0]  cfg_win = '0;
  logic [15:0] cfg_base = '0;
  logic [3:0]  drv_present = 4'b1011;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = '0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, dec_chan, dec_miss, dec_size_err;
  logic [1:0]  dec_region, drv_idx;
  logic [3:0]  dec_offset, drv_offset;
  logic        drv_req, drv_write, drv_ctl, resp_valid;
  logic [15:0] drv_wdata, drv_rdata, rd_cnt = '0, lo_seen = '0;
  logic [31:0] resp_data;

  always #5 clk = ~clk;

  disk_window_decoder i_disk_window_decoder (.*);

  // drive read data: a counter so each beat returns a different word
  assign drv_rdata = 16'h5A00 ^ rd_cnt;
  always @(posedge clk) if (drv_req) rd_cnt <= rd_cnt + 16'd1;

  typedef struct {
    logic [1:0] idx; logic wr; logic ctl; logic [3:0] off; logic [15:0] data; logic [1:0] kind; string rq;
  } exp_t;
  exp_t q[$];

  int errors = 0, checks = 0;
  bit done = 0;
  logic [15:0] mbase [5] = '{default: 16'h0};
  logic        msel  [2] = '{default: 1'b0};

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic int span(input int w);
    return (w == 4) ? 16 : ((w % 2 == 1) ? 4 : 8);
  endfunction

  task automatic setbase(input int w, input logic [15:0] b);
    @(negedge clk);
    cfg_we = 1'b1; cfg_win = 3'(w); cfg_base = b;
    @(posedge clk); #1 cfg_we = 1'b0;
    if (b != 0 && w < 5) mbase[w] = b;
  endtask

  // driver: predicts decode and pushes expected beats
  task automatic acc(input bit w, input logic [1:0] sz, input logic [15:0] a,
                     input logic [31:0] d, input string rq);
    int win = -1, off = 0, rg, ch, idx;
    bit reg_acc, dport, szok, selw, bitv;
    exp_t e;
    for (int i = 0; i < 5; i++)
      if (win < 0 && a >= mbase[i] && (int'(a) - int'(mbase[i])) < span(i)) win = i;
    if (win >= 0) off = int'(a) - int'(mbase[win]);
    rg = (win < 0) ? 3 : (win == 4) ? 2 : (win % 2);
    ch = (win < 0) ? 0 : (win == 4) ? int'(off >= 8) : (win / 2);
    reg_acc = (rg == 0 || rg == 1);
    dport = (rg == 0 && off == 0);
    szok = dport ? (sz == 1 || sz == 2) : (sz == 0);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_size = sz; req_addr = a; req_wdata = d;
    #1;
    if (io_en) begin
      chk(dec_region == 2'(rg), rq, "region", 32'(dec_region), 32'(rg));
      if (win >= 0) chk(dec_offset == 4'(off) && dec_chan == 1'(ch), rq, "chan/offset",
                        {dec_chan, dec_offset}, {1'(ch), 4'(off)});
    end
    chk(dec_miss == (io_en && win < 0), rq, "miss flag", 32'(dec_miss), 32'(io_en && win < 0));
    chk(dec_size_err == (io_en && reg_acc && !szok), rq, "size error flag",
        32'(dec_size_err), 32'(io_en && reg_acc && !szok));
    if (io_en && reg_acc && szok) begin
      selw = w && rg == 0 && off == 6 && sz == 0;
      if (selw) msel[ch] = d[4];
      bitv = msel[ch];
      idx = ch * 2 + int'(bitv);
      if (drv_present[idx]) begin
        e.idx = 2'(idx); e.wr = w; e.ctl = (rg == 1); e.off = 4'(off); e.rq = rq;
        e.kind = sz; e.data = (sz == 0) ? {8'h00, d[7:0]} : d[15:0];
        q.push_back(e);
        if (sz == 2) begin e.kind = 2'd3; e.data = d[31:16]; q.push_back(e); end
      end
    end
    @(posedge clk); #1 req_valid = 1'b0;
  endtask

  // monitor: pops and compares beats and read results
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (drv_req) begin
        if (q.size() == 0) chk(1'b0, "R10", "unexpected drive beat", {14'h0, drv_idx, drv_wdata}, 32'h0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(drv_idx == e.idx && drv_write == e.wr && drv_ctl == e.ctl && drv_offset == e.off &&
              drv_wdata == e.data, e.rq, "drive beat",
              {8'h0, drv_idx, drv_write, drv_ctl, drv_offset, drv_wdata},
              {8'h0, e.idx, e.wr, e.ctl, e.off, e.data});
          if (!e.wr) begin
            case (e.kind)
              2'd0: chk(resp_valid && resp_data == {24'h0, drv_rdata[7:0]}, "R11", "byte read", resp_data, {24'h0, drv_rdata[7:0]});
              2'd1: chk(resp_valid && resp_data == {16'h0, drv_rdata}, "R11", "half read", resp_data, {16'h0, drv_rdata});
              2'd2: begin chk(!resp_valid, "R11", "early response", 32'(resp_valid), 32'h0); lo_seen = drv_rdata; end
              default: chk(resp_valid && resp_data == {drv_rdata, lo_seen}, "R11", "word read", resp_data, {drv_rdata, lo_seen});
            endcase
          end
        end
      end else if (resp_valid) chk(1'b0, "R11", "response without beat", resp_data, 32'h0);
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && drv_req == 1'b0 && resp_valid == 1'b0, "R7", "reset state",
        {req_ready, drv_req, resp_valid}, 32'h4);
    setbase(0, 16'h01F0); setbase(1, 16'h03F4); setbase(2, 16'h0170);
    setbase(3, 16'h0374); setbase(4, 16'hC000);
    setbase(0, 16'h0000);           // R2: zero ignored
    setbase(7, 16'h0800);           // R2: bad window number ignored
    @(negedge clk); io_en = 1'b1;
    acc(1, 0, 16'h01F2, 32'h0000_00A5, "R2");     // still at 0x1F0, drive 0 (R5 reset)
    acc(0, 0, 16'h01F7, 32'h0, "R1");
    acc(1, 0, 16'h01F6, 32'h0000_0010, "R5");     // select drive 1, write goes there
    acc(1, 0, 16'h01F3, 32'h0000_003C, "R6");
    acc(0, 1, 16'h01F0, 32'h0, "R7");
    acc(1, 2, 16'h01F0, 32'hDEAD_BEEF, "R7");
    acc(0, 2, 16'h01F0, 32'h0, "R7");
    acc(1, 0, 16'h03F6, 32'h0000_0004, "R6");     // control block, drive 1
    acc(0, 0, 16'h03F4, 32'h0, "R8");              // control offset 0 is byte-only
    acc(1, 0, 16'h0172, 32'h0000_0011, "R10");    // drive 2 absent: dropped
    acc(1, 0, 16'h0176, 32'h0000_00F0, "R5");     // select drive 3
    acc(0, 1, 16'h0170, 32'h0, "R6");
    acc(1, 0, 16'h0176, 32'h0000_0000, "R10");    // back to drive 2: dropped
    acc(0, 0, 16'h0175, 32'h0, "R10");
    acc(1, 1, 16'h01F2, 32'h0, "R8");
    acc(1, 0, 16'h01F0, 32'h0, "R8");
    acc(0, 3, 16'h03F5, 32'h0, "R8");
    acc(0, 0, 16'h0500, 32'h0, "R4");
    acc(0, 0, 16'hC002, 32'h0, "R3");
    acc(1, 2, 16'hC00A, 32'h1234_5678, "R3");
    setbase(2, 16'h01F0);                          // overlap: primary command wins
    acc(1, 0, 16'h01F3, 32'h0000_0077, "R1");
    setbase(2, 16'h0170);
    @(negedge clk); io_en = 1'b0;
    acc(1, 0, 16'h01F6, 32'h0000_0000, "R9");     // ignored
    acc(0, 0, 16'h9999, 32'h0, "R9");
    @(negedge clk); io_en = 1'b1;
    acc(0, 0, 16'h01F5, 32'h0, "R9");             // still drive 1
    acc(1, 2, 16'h01F0, 32'hCAFE_0001, "R7");
    acc(0, 0, 16'h01F1, 32'h0, "R7");             // immediately after split
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R10", "beats still expected", 32'(q.size()), 32'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL R7 watchdog: actual=%h expected=%h", 32'h1, 32'h0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule